// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block keeps a 24-bit up/down position count for one axis of a rotary or linear encoder. The two encoder phases first pass through a synchroniser and a digital noise filter. The filter samples on ticks from an 8-bit programmable prescaler, and it takes a new level only once that level has held for two ticks in a row. If a pending level reverses before it is taken, a sticky noise flag is raised.

The filtered phases are decoded in one of four ways: as a clock/direction pair, or as quadrature at one, two or four counts per encoder cycle. Each decoded step moves the counter in one of two arithmetics, plain binary or six-digit packed BCD. At the ends of the range the counter follows one of four policies: free wrap, modulo-N, clamp between zero and the preset value, or a one-shot wrap that halts the counter until the next load.

The host side drives the preset value, the compare value and the mode pins directly. A load strobe copies the preset value into the counter, and a latch strobe takes a snapshot of the count without disturbing counting. A compare output shows when the count equals the compare value.

Top module: `qpos_counter`

## Requirements
- R1: After reset, `cnt_o`, `latch_o` and `noise_err_o` are all zero.
- R2: The prescaler makes a sample tick every `psc_div_i`+1 clocks. A filtered input takes a new level only when that level has been sampled on two consecutive ticks. With `psc_div_i`=0, a clean edge on `a_i` changes `cnt_o` on the 5th rising clock edge after the input changes. A pulse that lasts fewer than `psc_div_i`+1 clocks is never counted.
- R3: `noise_err_o` is set when, at a tick, a pending level that differs from the accepted level has already reversed. It stays set until `err_clr_i` is high at a clock edge. If a set and a clear fall in the same cycle, the set wins.
- R4: `quad_mode_i` selects the quadrature decode. The value 3 counts every edge of either phase. The value 2 counts every edge of A. The value 1 counts only the rising edges of A. The count goes up when A leads B, that is, when {A,B} steps 00→10→11→01→00. One full encoder cycle therefore moves the count by 4, 2 or 1.
- R5: `quad_mode_i`=0 is clock/direction mode. Each rising edge of A moves the count by one: up when B=1 and down when B=0. Edges of B never count.
- R6: `cnt_mode_i`=0 is free-wrap mode. Counting up from the top value gives 0, and counting down from 0 gives the top value. The top value is 0xFFFFFF in binary and 0x999999 in BCD.
- R7: `cnt_mode_i`=1 is modulo-N mode. Counting up from a count equal to `preset_i` gives 0. Counting down from 0 gives `preset_i`.
- R8: `cnt_mode_i`=2 is range-limit mode. The count holds at `preset_i` while steps go up, and it holds at 0 while steps go down. It moves again as soon as the direction reverses.
- R9: `cnt_mode_i`=3 is one-shot mode. An overflow or underflow wraps the count the same way as in mode 0, and after that every step is ignored until a load.
- R10: When `bcd_i`=1, each 4-bit digit counts 0 to 9. A digit at 9 that counts up becomes 0 and carries into the next digit. A digit at 0 that counts down becomes 9 and borrows from the next digit.
- R11: When `load_i` is high at a clock edge, `cnt_o` takes the value of `preset_i`. This takes priority over a step in the same cycle, and it releases the one-shot halt.
- R12: When `latch_i` is high at a clock edge, `latch_o` takes the count from before that edge. A step in the same cycle still changes `cnt_o`.
- R13: `match_o` is high exactly when `cnt_o` equals `cmp_val_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder phase A, or the count clock in clock/direction mode |
| b_i | input | 1 | Encoder phase B, or the direction in clock/direction mode |
| psc_div_i | input | 8 | Filter prescaler divisor minus one |
| quad_mode_i | input | 2 | Decode select: 0 clock/direction, 1 x1, 2 x2, 3 x4 |
| cnt_mode_i | input | 2 | End-of-range policy: 0 free, 1 modulo, 2 limit, 3 one-shot |
| bcd_i | input | 1 | Selects BCD arithmetic |
| preset_i | input | 24 | Preset value for load, and the modulo or limit bound |
| load_i | input | 1 | Load strobe |
| latch_i | input | 1 | Snapshot strobe |
| cmp_val_i | input | 24 | Compare value |
| err_clr_i | input | 1 | Clears the noise flag |
| cnt_o | output | 24 | Current count |
| latch_o | output | 24 | Snapshot of the count |
| match_o | output | 1 | Count equals the compare value |
| noise_err_o | output | 1 | Sticky noise flag |

## Verification
A decoded step can fall in the same cycle as a latch strobe or as a load strobe, and both overlaps have defined results. The bench provokes each overlap by driving one clean encoder edge with the prescaler at zero. It then counts four rising edges and raises the strobe for exactly the fifth edge, which is the edge on which the step lands. For the latch case, the snapshot must hold the old count while the count itself has advanced by one. For the load case, the count must equal the preset value and not show the step.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    QM_DIRCLK = 2'd0,
    QM_X1     = 2'd1,
    QM_X2     = 2'd2,
    QM_X4     = 2'd3
  } quad_mode_e;

  typedef enum logic [1:0] {
    CM_FREE    = 2'd0,
    CM_MODULO  = 2'd1,
    CM_LIMIT   = 2'd2,
    CM_ONESHOT = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/qpos_filter.sv
module qpos_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic lvl_o,
  output logic glitch_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp_q;
  logic cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      smp_q  <= 1'b0;
      lvl_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (tick_i) begin
        smp_q <= cur;
        if (cur == smp_q && cur != lvl_o) lvl_o <= cur;
      end
    end
  end

  // pending level reversed before acceptance
  assign glitch_o = tick_i && (smp_q != lvl_o) && (cur != smp_q);
endmodule

// File: rtl/qpos_decoder.sv
module qpos_decoder
  import qpos_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  quad_mode_e mode_i,
  output logic       step_o,
  output logic       up_o
);
  logic a_q, b_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg = a_i ^ a_q;
  assign b_chg = b_i ^ b_q;

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b0;
    unique case (mode_i)
      QM_X4: begin
        step_o = a_chg ^ b_chg;
        up_o   = a_i ^ b_q;
      end
      QM_X2: begin
        step_o = a_chg & ~b_chg;
        up_o   = a_i ^ b_i;
      end
      QM_X1: begin
        step_o = a_chg & ~b_chg & a_i;
        up_o   = a_i ^ b_i;
      end
      default: begin
        step_o = a_chg & a_i;
        up_o   = b_i;
      end
    endcase
  end
endmodule

// File: rtl/qpos_core.sv
module qpos_core
  import qpos_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  cnt_mode_e        mode_i,
  input  logic             bcd_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             halt_o
);
  localparam int DIG = CNT_W / 4;

  function automatic logic [CNT_W-1:0] all_nines();
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < DIG; i++) r[4*i +: 4] = 4'd9;
    return r;
  endfunction

  localparam logic [CNT_W-1:0] BCD_TOP = all_nines();

  function automatic logic [CNT_W-1:0] bcd_step(input logic [CNT_W-1:0] v, input logic up);
    logic [CNT_W-1:0] r;
    logic c;
    logic [3:0] d;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIG; i++) begin
      d = v[4*i +: 4];
      if (c) begin
        if (up) begin
          if (d >= 4'd9) d = 4'd0;
          else begin d = d + 4'd1; c = 1'b0; end
        end else begin
          if (d == 4'd0) d = 4'd9;
          else begin d = d - 4'd1; c = 1'b0; end
        end
      end
      r[4*i +: 4] = d;
    end
    return r;
  endfunction

  logic [CNT_W-1:0] cnt_d, top_v, max_v, inc_v, dec_v;
  logic halt_d;

  assign max_v = bcd_i ? BCD_TOP : '1;
  assign top_v = (mode_i == CM_MODULO || mode_i == CM_LIMIT) ? preset_i : max_v;
  assign inc_v = bcd_i ? bcd_step(cnt_o, 1'b1) : cnt_o + 1'b1;
  assign dec_v = bcd_i ? bcd_step(cnt_o, 1'b0) : cnt_o - 1'b1;

  always_comb begin
    cnt_d  = cnt_o;
    halt_d = halt_o;
    if (load_i) begin
      cnt_d  = preset_i;
      halt_d = 1'b0;
    end else if (step_i && !halt_o) begin
      if (up_i) begin
        if (cnt_o == top_v) begin
          unique case (mode_i)
            CM_LIMIT:   cnt_d = cnt_o;
            CM_ONESHOT: begin cnt_d = '0; halt_d = 1'b1; end
            default:    cnt_d = '0;
          endcase
        end else cnt_d = inc_v;
      end else begin
        if (cnt_o == '0) begin
          unique case (mode_i)
            CM_LIMIT:   cnt_d = cnt_o;
            CM_MODULO:  cnt_d = preset_i;
            CM_ONESHOT: begin cnt_d = max_v; halt_d = 1'b1; end
            default:    cnt_d = max_v;
          endcase
        end else cnt_d = dec_v;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      halt_o <= 1'b0;
    end else begin
      cnt_o  <= cnt_d;
      halt_o <= halt_d;
    end
  end
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [PSC_W-1:0] psc_div_i,
  input  logic [1:0]       quad_mode_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic             bcd_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             load_i,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             err_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             match_o,
  output logic             noise_err_o
);
  localparam int NCH = 2;

  logic [PSC_W-1:0] psc_q;
  logic tick;
  logic [NCH-1:0] raw, filt, glitch;
  logic step_en, step_up, halt;

  assign tick = (psc_q == psc_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= tick ? '0 : psc_q + 1'b1;
  end

  assign raw = {b_i, a_i};

  for (genvar g = 0; g < NCH; g++) begin : g_flt
    qpos_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .raw_i    (raw[g]),
      .lvl_o    (filt[g]),
      .glitch_o (glitch[g])
    );
  end

  qpos_decoder u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (filt[0]),
    .b_i    (filt[1]),
    .mode_i (quad_mode_e'(quad_mode_i)),
    .step_o (step_en),
    .up_o   (step_up)
  );

  qpos_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_en),
    .up_i     (step_up),
    .mode_i   (cnt_mode_e'(cnt_mode_i)),
    .bcd_i    (bcd_i),
    .load_i   (load_i),
    .preset_i (preset_i),
    .cnt_o    (cnt_o),
    .halt_o   (halt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o     <= '0;
      noise_err_o <= 1'b0;
    end else begin
      if (latch_i) latch_o <= cnt_o;
      if (|glitch)        noise_err_o <= 1'b1;
      else if (err_clr_i) noise_err_o <= 1'b0;
    end
  end

  assign match_o = (cnt_o == cmp_val_i);
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             latch_i,
  input logic             err_clr_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] latch_o,
  input logic             noise_err_o,
  input logic             step_en,
  input logic             halt
);
  // R11
  load_takes_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> cnt_o == $past(preset_i));

  // R12
  latch_snapshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latch_i) |-> latch_o == $past(cnt_o));

  // R3
  noise_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(noise_err_o) && !$past(err_clr_i)) |-> noise_err_o);

  // R2
  no_step_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && !$past(step_en)) |-> $stable(cnt_o));

  // R9
  halt_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(halt) && !$past(load_i)) |-> $stable(cnt_o));
endmodule

bind qpos_counter qpos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .latch_i     (latch_i),
  .err_clr_i   (err_clr_i),
  .preset_i    (preset_i),
  .cnt_o       (cnt_o),
  .latch_o     (latch_o),
  .noise_err_o (noise_err_o),
  .step_en     (step_en),
  .halt        (halt)
);

// File: tb/qpos_counter_test.sv
`timescale 1ns/1ps
module qpos_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic [7:0] psc = 8'd0;
  logic [1:0] qmode = 2'd3, cmode = 2'd0;
  logic bcd = 1'b0;
  logic [23:0] preset = '0, cmpv = 24'hFFFFFF;
  logic load = 1'b0, latch = 1'b0, eclr = 1'b0;
  logic [23:0] cnt, lat;
  logic match, nerr;

  int checks = 0, errors = 0;
  int settle_n = 8;
  logic [1:0] qidx = 2'd0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qpos_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .psc_div_i(psc),
    .quad_mode_i(qmode), .cnt_mode_i(cmode), .bcd_i(bcd), .preset_i(preset),
    .load_i(load), .latch_i(latch), .cmp_val_i(cmpv), .err_clr_i(eclr),
    .cnt_o(cnt), .latch_o(lat), .match_o(match), .noise_err_o(nerr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (settle_n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_q(input logic [1:0] i);
    qidx = i;
    a = (i == 2'd1) || (i == 2'd2);
    b = i[1];
  endtask

  task automatic qedge(input bit up);
    set_q(up ? qidx + 2'd1 : qidx - 2'd1);
    settle();
  endtask

  task automatic do_load(input logic [23:0] v);
    preset = v;
    load = 1'b1;
    @(posedge clk); @(negedge clk);
    load = 1'b0;
  endtask

  function automatic logic [23:0] to_bcd(input int v);
    logic [23:0] r;
    int x;
    x = ((v % 1000000) + 1000000) % 1000000;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    logic [23:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt, 0); chk("R1 latch", lat, 0); chk("R1 noise", nerr, 0);

    // R2 latency, R12 latch coincident with step
    set_q(2'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 before 5th edge", cnt, 0);
    latch = 1'b1;
    @(posedge clk); @(negedge clk);
    latch = 1'b0;
    chk("R2 at 5th edge", cnt, 1);
    chk("R12 latch old value", lat, 0);
    settle();

    // R11 load coincident with step
    set_q(2'd2);
    repeat (4) @(posedge clk);
    @(negedge clk);
    preset = 24'h000040; load = 1'b1;
    @(posedge clk); @(negedge clk);
    load = 1'b0;
    chk("R11 load beats step", cnt, 24'h40);
    settle();
    chk("R11 step not applied later", cnt, 24'h40);

    // R4 x4 sweep with R13 match
    do_load(0); set_q(2'd0); settle(); do_load(0);
    cmpv = 24'd20; e = 0;
    for (int k = 0; k < 37; k++) begin
      qedge(1); e++;
      chk("R4 x4 up", cnt, e);
      chk("R13 match", match, (e == 20));
    end
    for (int k = 0; k < 10; k++) begin qedge(0); e--; end
    chk("R4 x4 down", cnt, e);

    // R4 x2 and x1: full cycles
    for (int m = 1; m <= 2; m++) begin
      qmode = 2'(m); do_load(0); e = 0;
      for (int c = 0; c < 3; c++) begin
        for (int s = 0; s < 4; s++) qedge(1);
        e += m;
        chk("R4 x1/x2 up", cnt, e);
      end
      for (int s = 0; s < 4; s++) qedge(0);
      e -= m;
      chk("R4 x1/x2 down", cnt, e);
    end

    // R5 clock/direction
    qmode = 2'd0; do_load(0);
    b = 1'b1; settle();
    chk("R5 B edge ignored", cnt, 0);
    for (int k = 0; k < 3; k++) begin a = 1'b1; settle(); a = 1'b0; settle(); end
    chk("R5 up", cnt, 3);
    b = 1'b0; settle();
    chk("R5 B fall ignored", cnt, 3);
    a = 1'b1; settle(); a = 1'b0; settle();
    chk("R5 down", cnt, 2);
    set_q(2'd0); qmode = 2'd3; settle();

    // R6 free wrap, binary and BCD
    cmode = 2'd0; do_load(0);
    qedge(0); chk("R6 bin underflow", cnt, 24'hFFFFFF);
    qedge(1); chk("R6 bin overflow", cnt, 0);
    bcd = 1'b1;
    qedge(0); chk("R6 bcd underflow", cnt, 24'h999999);
    qedge(1); chk("R6 bcd overflow", cnt, 0);

    // R10 BCD sweep up and down across wrap
    do_load(0); e = 0;
    for (int k = 0; k < 150; k++) begin qedge(1); e++; chk("R10 bcd up", cnt, to_bcd(e)); end
    for (int k = 0; k < 160; k++) begin qedge(0); e--; chk("R10 bcd down", cnt, to_bcd(e)); end
    bcd = 1'b0;

    // R7 modulo 6
    cmode = 2'd1; do_load(0); preset = 24'd5; e = 0;
    for (int k = 0; k < 14; k++) begin qedge(1); e = (e + 1) % 6; chk("R7 modulo up", cnt, e); end
    for (int k = 0; k < 14; k++) begin qedge(0); e = (e + 5) % 6; chk("R7 modulo down", cnt, e); end

    // R8 range limit
    cmode = 2'd2; do_load(0); preset = 24'd3; e = 0;
    for (int k = 0; k < 5; k++) begin qedge(1); if (e < 3) e++; chk("R8 upper clamp", cnt, e); end
    for (int k = 0; k < 5; k++) begin qedge(0); if (e > 0) e--; chk("R8 lower clamp", cnt, e); end
    qedge(1); chk("R8 reversal releases", cnt, 1);

    // R9 one-shot
    cmode = 2'd3; do_load(2);
    qedge(0); qedge(0); chk("R9 before wrap", cnt, 0);
    qedge(0); chk("R9 wrap", cnt, 24'hFFFFFF);
    qedge(1); qedge(1); chk("R9 halted", cnt, 24'hFFFFFF);
    do_load(7); qedge(1); chk("R9 load releases", cnt, 8);
    cmode = 2'd0;

    // R3 glitch with prescaler 0
    old = cnt;
    a = ~a; @(negedge clk); a = ~a;
    settle();
    chk("R3 noise set", nerr, 1);
    chk("R2 glitch not counted", cnt, old);
    repeat (20) @(negedge clk);
    chk("R3 noise sticky", nerr, 1);
    eclr = 1'b1; @(posedge clk); @(negedge clk); eclr = 1'b0;
    chk("R3 noise cleared", nerr, 0);

    // R2 prescaler 7: short pulse rejected, long edge delayed
    psc = 8'd7; settle_n = 40;
    a = ~a; repeat (6) @(negedge clk); a = ~a;
    settle();
    chk("R2 short pulse rejected", cnt, old);
    eclr = 1'b1; @(negedge clk); eclr = 1'b0;
    set_q(qidx + 2'd1);
    repeat (6) @(negedge clk);
    chk("R2 prescaled edge not early", cnt, old);
    settle();
    chk("R2 prescaled edge counted", cnt, old + 24'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule